// File: doc/BRIEF.md
# Two-Wire Slave Port with Software Pin Mode

This block connects a microcontroller core to a two-wire I2C-compatible bus. The core sees three byte-wide registers: the slave's own address, a data byte, and a control byte. With the mode bit clear, a hardware engine acts as a 7-bit-addressed slave. It watches for START and STOP, acknowledges its own address and takes the transfer direction from the R/W bit. It then receives or sends bytes and raises a sticky flag after each byte.

With the mode bit set, the engine is held idle. Software then drives the clock and data pads directly from control bits and reads the data line back through a captured input bit. This lets software run a bus master by toggling pins. Both pads are open-drain: the block only ever asks a pad to pull low.

Top module: `tws_port`

## Requirements
- R1: After reset the address register reads 0x55, the data register reads 0x00, the control register reads 0x00, and neither pad is pulled low.
- R2: Register offset 0 is the address (bits 6:0 writable, bit 7 reads 0), offset 1 is data, offset 2 is control, and offset 3 reads 0.
- R3: In slave mode, after a START, the engine shifts in 7 address bits MSB first, then R/W. When the address matches it pulls SDA low during the 9th clock. On a mismatch it stays silent and ignores the bus until the next START.
- R4: In a write transfer, each data byte is taken MSB first and acknowledged. Once the 8th bit has been clocked, the byte reads back at offset 1 and control bit 0 (the byte flag) is set.
- R5: With R/W = 1, control bit 1 is set and the byte last written to offset 1 is sent MSB first, with bits changing after SCL falls. The flag is set after the 8th bit. A master ACK starts the next byte from offset 1; a NACK releases SDA and clears bit 1.
- R6: A STOP returns the engine to idle from any state, clears control bit 1 and abandons a partial byte without setting the flag.
- R7: Control bit 0 is set only by the engine. A host write to control with bit 0 = 0 clears it, a write with bit 0 = 1 leaves it unchanged, and the irq output follows it.
- R8: With control bit 2 = 1 the engine is held idle: it acknowledges nothing, never pulls SDA and keeps bit 1 at 0.
- R9: With control bit 3 = 1, SCL is pulled low exactly when bit 5 = 0, SDA is pulled low exactly when bit 6 = 1 and bit 7 = 0, and the engine does not respond.
- R10: With control bit 3 = 1 and bit 6 = 0, the SDA level is captured into control bit 4 on each rising SCL edge seen at the pin. Otherwise bit 4 holds.
- R11: Control bits 4 and 1 are not writable by the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Byte flag (control bit 0) |
| scl_in | input | 1 | SCL level at the pad |
| sda_in | input | 1 | SDA level at the pad |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |

## Verification
Slave traffic is run with random data bytes and random wrong addresses. This separates a correct address compare from one that acknowledges everything, and a correct MSB-first shifter from a reversed or off-by-one one. Read transfers use a fresh byte before each master ACK and end with a NACK, which shows whether the send register is reloaded and whether the engine lets go on a NACK. STOPs are placed both mid-byte and during sending. Random control words in software mode sweep all pad-drive combinations. Captures with the data driver on and off show whether the input bit samples only on a clock edge and only when the line is released.

// File: rtl/tws_pkg.sv
package tws_pkg;
   typedef enum logic [2:0] {
      SL_IDLE, SL_ADDR, SL_AACK, SL_RX, SL_RACK, SL_TX, SL_TACK, SL_TNXT
   } slv_state_t;

   localparam logic [1:0] OFS_ADDR = 2'd0;
   localparam logic [1:0] OFS_DATA = 2'd1;
   localparam logic [1:0] OFS_CTRL = 2'd2;

   localparam int CB_FLAG = 0;
   localparam int CB_DIR  = 1;
   localparam int CB_HOLD = 2;
   localparam int CB_MODE = 3;
   localparam int CB_SIN  = 4;
   localparam int CB_SCLO = 5;
   localparam int CB_SDAE = 6;
   localparam int CB_SDAO = 7;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tws_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '1;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/tws_slave.sv
module tws_slave import tws_pkg::*; #(
   parameter int DW = 8,
   parameter int AW = 7
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold,
   input  logic          scl_s,
   input  logic          sda_s,
   input  logic [AW-1:0] own_addr,
   input  logic [DW-1:0] tx_byte,
   output logic          sda_low,
   output logic [DW-1:0] rx_byte,
   output logic          byte_done,
   output logic          tx_dir
);
   localparam int CW = $clog2(DW + 1);
   localparam logic [CW-1:0] FULL = CW'(DW);

   generate
      if (AW != DW - 1) begin : g_bad_aw
         $error("tws_slave: AW must be DW-1");
      end
   endgenerate

   slv_state_t    st;
   logic [CW-1:0] cnt;
   logic [DW-1:0] sh;
   logic          scl_q, sda_q;
   logic          rise, fall, start, stop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) {scl_q, sda_q} <= 2'b11;
      else        {scl_q, sda_q} <= {scl_s, sda_s};
   end

   assign rise  = scl_s & ~scl_q;
   assign fall  = ~scl_s & scl_q;
   assign start = scl_s & scl_q & sda_q & ~sda_s;
   assign stop  = scl_s & scl_q & ~sda_q & sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= SL_IDLE; cnt <= '0; sh <= '0; sda_low <= 1'b0;
         tx_dir <= 1'b0; rx_byte <= '0; byte_done <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (hold) begin
            st <= SL_IDLE; cnt <= '0; sda_low <= 1'b0; tx_dir <= 1'b0;
         end else if (start) begin
            st <= SL_ADDR; cnt <= '0; sh <= '0; sda_low <= 1'b0; tx_dir <= 1'b0;
         end else if (stop) begin
            st <= SL_IDLE; sda_low <= 1'b0; tx_dir <= 1'b0;
         end else begin
            case (st)
               SL_ADDR: begin
                  if (rise) begin
                     sh  <= {sh[DW-2:0], sda_s};
                     cnt <= cnt + 1'b1;
                  end else if (fall && cnt == FULL) begin
                     if (sh[DW-1:1] == own_addr) begin
                        st <= SL_AACK; sda_low <= 1'b1; tx_dir <= sh[0];
                     end else begin
                        st <= SL_IDLE;
                     end
                  end
               end
               SL_AACK, SL_RACK, SL_TNXT: begin
                  if (fall) begin
                     cnt <= '0;
                     if (tx_dir) begin
                        st <= SL_TX; sh <= tx_byte; sda_low <= ~tx_byte[DW-1];
                     end else begin
                        st <= SL_RX; sda_low <= 1'b0;
                     end
                  end
               end
               SL_RX: begin
                  if (rise) begin
                     sh  <= {sh[DW-2:0], sda_s};
                     cnt <= cnt + 1'b1;
                  end else if (fall && cnt == FULL) begin
                     rx_byte <= sh; byte_done <= 1'b1; sda_low <= 1'b1; st <= SL_RACK;
                  end
               end
               SL_TX: begin
                  if (rise) begin
                     cnt <= cnt + 1'b1;
                  end else if (fall) begin
                     if (cnt == FULL) begin
                        sda_low <= 1'b0; byte_done <= 1'b1; st <= SL_TACK;
                     end else begin
                        sh <= {sh[DW-2:0], 1'b0}; sda_low <= ~sh[DW-2];
                     end
                  end
               end
               SL_TACK: begin
                  if (rise) begin
                     if (sda_s) begin st <= SL_IDLE; tx_dir <= 1'b0; end
                     else       st <= SL_TNXT;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   p_release_on_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> !sda_low);
   p_pull_only_ack_or_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sda_low |-> (st == SL_AACK || st == SL_RACK || st == SL_TX));
   p_dir_from_address_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_dir) |-> $past(st) == SL_ADDR);
   p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FULL);
   p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> !byte_done);
endmodule

// File: rtl/tws_pad.sv
module tws_pad (
   input  logic mode,
   input  logic sdo,
   input  logic sde,
   input  logic sco,
   input  logic eng_sda_low,
   output logic scl_pull,
   output logic sda_pull
);
   assign scl_pull = mode & ~sco;
   assign sda_pull = mode ? (sde & ~sdo) : eng_sda_low;
endmodule

// File: rtl/tws_port.sv
module tws_port import tws_pkg::*; #(
   parameter int ADDR_RST    = 'h55,
   parameter int SYNC_STAGES = 2,
   parameter bit SIN_ON_RISE = 1'b1
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] reg_sel,
   input  logic       reg_we,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       irq,
   input  logic       scl_in,
   input  logic       sda_in,
   output logic       scl_pull,
   output logic       sda_pull
);
   localparam int DW = 8;
   localparam int AW = DW - 1;

   generate
      if (ADDR_RST < 0 || ADDR_RST >= (1 << AW)) begin : g_bad_addr
         $error("tws_port: ADDR_RST does not fit the address width");
      end
   endgenerate

   logic [1:0]    sync_q;
   logic          scl_s, sda_s, scl_prev, scl_edge;
   logic [AW-1:0] own_addr;
   logic [DW-1:0] tx_byte, rx_byte;
   logic          c_sdo, c_sde, c_sco, c_mode, c_hold, flag, sin;
   logic          eng_sda_low, eng_done, eng_dir;
   logic          wr_addr, wr_data, wr_ctrl;

   tws_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(sync_q));
   assign scl_s = sync_q[1];
   assign sda_s = sync_q[0];

   tws_slave #(.DW(DW), .AW(AW)) u_slave (
      .clk(clk), .rst_n(rst_n), .hold(c_mode | c_hold),
      .scl_s(scl_s), .sda_s(sda_s), .own_addr(own_addr), .tx_byte(tx_byte),
      .sda_low(eng_sda_low), .rx_byte(rx_byte), .byte_done(eng_done), .tx_dir(eng_dir));

   tws_pad u_pad (
      .mode(c_mode), .sdo(c_sdo), .sde(c_sde), .sco(c_sco),
      .eng_sda_low(eng_sda_low), .scl_pull(scl_pull), .sda_pull(sda_pull));

   generate
      if (SIN_ON_RISE) begin : g_rise
         assign scl_edge = scl_s & ~scl_prev;
      end else begin : g_fall
         assign scl_edge = ~scl_s & scl_prev;
      end
   endgenerate

   assign wr_addr = reg_we && reg_sel == OFS_ADDR;
   assign wr_data = reg_we && reg_sel == OFS_DATA;
   assign wr_ctrl = reg_we && reg_sel == OFS_CTRL;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_addr <= AW'(ADDR_RST);
         tx_byte  <= '0;
         {c_sdo, c_sde, c_sco, c_mode, c_hold} <= '0;
         flag     <= 1'b0;
         sin      <= 1'b0;
         scl_prev <= 1'b1;
      end else begin
         scl_prev <= scl_s;
         if (wr_addr) own_addr <= reg_wdata[AW-1:0];
         if (wr_data) tx_byte <= reg_wdata;
         if (wr_ctrl) begin
            c_sdo  <= reg_wdata[CB_SDAO];
            c_sde  <= reg_wdata[CB_SDAE];
            c_sco  <= reg_wdata[CB_SCLO];
            c_mode <= reg_wdata[CB_MODE];
            c_hold <= reg_wdata[CB_HOLD];
         end
         flag <= eng_done | (flag & ~(wr_ctrl & ~reg_wdata[CB_FLAG]));
         if (c_mode && !c_sde && scl_edge) sin <= sda_s;
      end
   end

   always_comb begin
      case (reg_sel)
         OFS_ADDR: reg_rdata = {1'b0, own_addr};
         OFS_DATA: reg_rdata = rx_byte;
         OFS_CTRL: reg_rdata = {c_sdo, c_sde, c_sco, sin, c_mode, c_hold, eng_dir, flag};
         default:  reg_rdata = '0;
      endcase
   end

   assign irq = flag;

   p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !(wr_ctrl && !reg_wdata[CB_FLAG])) |=> flag);
   p_sin_only_on_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !scl_edge |=> $stable(sin));
   p_engine_quiet_master_r9: assert property (@(posedge clk) disable iff (!rst_n)
      c_mode |=> (!eng_dir && !eng_sda_low));
endmodule

// File: tb/tws_port_tb.sv
module tws_port_tb;
   localparam int Q = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] sel = '0;
   logic       we = 1'b0;
   logic [7:0] wd = '0;
   logic [7:0] rd;
   logic       irq, scl_pull, sda_pull;
   logic       m_scl_low = 1'b0, m_sda_low = 1'b0;
   logic       scl_line, sda_line;
   int         checks = 0, errors = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   assign scl_line = ~(scl_pull | m_scl_low);
   assign sda_line = ~(sda_pull | m_sda_low);

   tws_port u_dut (
      .clk(clk), .rst_n(rst_n), .reg_sel(sel), .reg_we(we), .reg_wdata(wd),
      .reg_rdata(rd), .irq(irq), .scl_in(scl_line), .sda_in(sda_line),
      .scl_pull(scl_pull), .sda_pull(sda_pull));

   function automatic logic [1:0] exp_pads(input logic [7:0] c);
      return {c[3] & ~c[5], c[3] & c[6] & ~c[7]};
   endfunction

   function automatic logic [7:0] exp_ctrl_rd(input logic [7:0] c);
      return c & 8'hEC;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic hw(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); sel = a; we = 1'b1; wd = d;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic hr(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); sel = a; #1; d = rd;
   endtask

   task automatic m_start;
      m_sda_low = 1'b0; waitn(Q);
      m_scl_low = 1'b0; waitn(Q);
      m_sda_low = 1'b1; waitn(Q);
      m_scl_low = 1'b1; waitn(Q);
   endtask

   task automatic m_stop;
      m_sda_low = 1'b1; waitn(Q);
      m_scl_low = 1'b0; waitn(Q);
      m_sda_low = 1'b0; waitn(Q);
   endtask

   task automatic send_bit(input logic b);
      m_sda_low = ~b; waitn(Q);
      m_scl_low = 1'b0; waitn(2*Q);
      m_scl_low = 1'b1; waitn(Q);
   endtask

   task automatic write_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      m_sda_low = 1'b0; waitn(Q);
      m_scl_low = 1'b0; waitn(Q);
      ack = ~sda_line; waitn(Q);
      m_scl_low = 1'b1; waitn(Q);
   endtask

   task automatic read_bits(output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         m_sda_low = 1'b0; waitn(Q);
         m_scl_low = 1'b0; waitn(Q);
         b[i] = sda_line; waitn(Q);
         m_scl_low = 1'b1; waitn(Q);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] r, b, x, y, own, bad;
      logic       ack;
      logic [7:0] bytes [4];
      void'($urandom(32'd20240611));

      waitn(3);
      chk("R1 pads after reset", {30'd0, scl_pull, sda_pull}, 32'd0);
      hr(OFS_A, r); chk("R1 address reset", r, 8'h55);
      hr(OFS_D, r); chk("R1 data reset", r, 8'h00);
      hr(OFS_C, r); chk("R1 control reset", r, 8'h00);
      rst_n = 1'b1; waitn(2);
      hr(OFS_A, r); chk("R1 address after release", r, 8'h55);
      hr(2'd3, r);  chk("R2 unused offset", r, 8'h00);

      own = 8'h3A;
      hw(OFS_A, 8'hBA); hr(OFS_A, r); chk("R2 address bit7 reads 0", r, 8'h3A);

      // write transfer with random data
      m_start;
      write_byte({own[6:0], 1'b0}, ack); chk("R3 address ack", ack, 1'b1);
      hr(OFS_C, r); chk("R5 direction clear on write", r[1], 1'b0);
      for (int k = 0; k < 4; k++) begin
         bytes[k] = 8'($urandom);
         write_byte(bytes[k], ack);
         chk("R4 data ack", ack, 1'b1);
         hr(OFS_D, r); chk("R4 received byte", r, bytes[k]);
         hr(OFS_C, r); chk("R4 flag set", r[0], 1'b1);
         chk("R7 irq follows flag", irq, 1'b1);
         hw(OFS_C, 8'h01); hr(OFS_C, r); chk("R7 write 1 keeps flag", r[0], 1'b1);
         hw(OFS_C, 8'h00); hr(OFS_C, r); chk("R7 write 0 clears flag", r[0], 1'b0);
      end
      m_stop;
      hw(OFS_C, 8'h01); hr(OFS_C, r); chk("R7 write 1 cannot set flag", r[0], 1'b0);

      // wrong addresses are ignored
      for (int k = 0; k < 4; k++) begin
         do bad = 8'($urandom) & 8'h7F; while (bad == own);
         m_start;
         write_byte({bad[6:0], 1'b0}, ack); chk("R3 no ack on mismatch", ack, 1'b0);
         write_byte(8'hC3, ack); chk("R3 ignored after mismatch", ack, 1'b0);
         m_stop;
         hr(OFS_D, r); chk("R3 data untouched", r, bytes[3]);
         hr(OFS_C, r); chk("R3 flag untouched", r[0], 1'b0);
      end

      // read transfer
      x = 8'($urandom) | 8'h01; y = 8'($urandom);
      hw(OFS_D, x);
      m_start;
      write_byte({own[6:0], 1'b1}, ack); chk("R3 read address ack", ack, 1'b1);
      hr(OFS_C, r); chk("R5 direction set", r[1], 1'b1);
      read_bits(b); chk("R5 first byte sent", b, x);
      hr(OFS_C, r); chk("R5 flag after send", r[0], 1'b1);
      hw(OFS_C, 8'h00);
      hw(OFS_D, y);
      send_bit(1'b0);
      read_bits(b); chk("R5 second byte reloaded", b, y);
      send_bit(1'b1);
      waitn(4);
      chk("R5 release after nack", sda_pull, 1'b0);
      hr(OFS_C, r); chk("R5 direction clear after nack", r[1], 1'b0);
      m_stop;
      hw(OFS_C, 8'h00);

      // STOP during send and mid-byte
      hw(OFS_D, 8'h80 | 8'($urandom));
      m_start;
      write_byte({own[6:0], 1'b1}, ack); chk("R6 read ack before stop", ack, 1'b1);
      m_stop;
      hr(OFS_C, r); chk("R6 direction clear after stop", r[1], 1'b0);
      chk("R6 sda released after stop", sda_pull, 1'b0);
      hw(OFS_C, 8'h00);
      m_start;
      write_byte({own[6:0], 1'b0}, ack);
      for (int i = 0; i < 4; i++) send_bit(1'b1);
      m_stop;
      hr(OFS_C, r); chk("R6 partial byte no flag", r[0], 1'b0);
      m_start;
      write_byte({own[6:0], 1'b0}, ack); chk("R6 new transfer after stop", ack, 1'b1);
      write_byte(8'h5A, ack);
      m_stop;
      hr(OFS_D, r); chk("R6 byte after restart", r, 8'h5A);
      hw(OFS_C, 8'h00);

      // engine held in reset
      hw(OFS_C, 8'h04);
      m_start;
      write_byte({own[6:0], 1'b1}, ack); chk("R8 no ack while held", ack, 1'b0);
      hr(OFS_C, r); chk("R8 direction stays clear", r, 8'h04);
      m_stop;
      hw(OFS_C, 8'h00);

      // software pin mode: pads
      for (int k = 0; k < 16; k++) begin
         b = 8'($urandom) | 8'h08;
         hw(OFS_C, b); waitn(2);
         chk("R9 pad drive", {30'd0, scl_pull, sda_pull}, {30'd0, exp_pads(b)});
         hr(OFS_C, r); chk("R11 read-only bits", r & 8'hEF, exp_ctrl_rd(b));
      end
      hw(OFS_C, 8'h28);
      m_start;
      write_byte({own[6:0], 1'b0}, ack); chk("R9 engine silent in pin mode", ack, 1'b0);
      m_stop;

      // input capture
      for (int k = 0; k < 8; k++) begin
         b = 8'($urandom);
         hw(OFS_C, 8'h08);
         m_sda_low = ~b[0]; waitn(4);
         hw(OFS_C, 8'h28 | ({7'd0, ~b[0]} << 4)); waitn(6);
         hr(OFS_C, r); chk("R10 capture on rising clock", r[4], b[0]);
         m_sda_low = b[0]; waitn(6);
         hr(OFS_C, r); chk("R10 hold without edge", r[4], b[0]);
         hw(OFS_C, 8'hC8); m_sda_low = b[0]; waitn(4);
         hw(OFS_C, 8'hE8); waitn(6);
         hr(OFS_C, r); chk("R10 hold while driving", r[4], b[0]);
         m_sda_low = 1'b0;
      end
      hw(OFS_C, 8'h00);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   localparam logic [1:0] OFS_A = 2'd0;
   localparam logic [1:0] OFS_D = 2'd1;
   localparam logic [1:0] OFS_C = 2'd2;
endmodule